// File: doc/BRIEF.md
# Embedded Logic Analyzer Capture Core

This block is an on-chip logic analyzer. It samples a 32-bit probe bus once on every rising edge of the design clock. Each sample is compared against a ternary trigger pattern, in which every bit must be 0, must be 1, or is ignored. Because only clock-edge samples are taken, a glitch between two edges cannot be observed. The same probe bits feed the trigger logic and the capture buffer.

The core is armed with a one-cycle pulse and then waits for a trigger. The trigger can come from a single pattern match or from a two-step sequence: a first pattern, then a second pattern on some later sample. The user can also force the trigger. From the triggering sample onward, the core stores a window of consecutive samples. When the window is full, it raises a done flag and ignores all further triggers until it is armed again. Captured samples are then read back by index, with the triggering sample at index zero. Pattern values and masks are loaded through a small synchronous write port.

Top module: `la_capture`

## Requirements
- R1: After reset, `armed_o`, `capturing_o`, `done_o` and `rd_valid_o` are all low. Both masks are cleared, so every bit is don't-care.
- R2: A pulse on `arm_i` puts the core in the armed state on the next clock (`armed_o` high) from any state. It clears `done_o` and any latched first-stage match.
- R3: The trigger compare is ternary. A `cfg_we_i` write stores `cfg_data_i` into the register picked by `cfg_sel_i`: 0 = first-stage value, 1 = first-stage mask, 2 = second-stage value, 3 = second-stage mask. A mask bit of 1 compares that bit and a mask bit of 0 makes it don't-care. With `seq_en_i` low, an armed core triggers on the first sample whose masked bits equal the first-stage value.
- R4: With `seq_en_i` high, a first-stage match is latched and does not trigger by itself. The core triggers on a later sample that matches the second stage. A second-stage match seen before any first-stage match does not trigger.
- R5: `force_i` while armed triggers on that sample, whatever the patterns say.
- R6: The triggering sample is stored at index 0. The samples of the following 511 clocks are stored at indices 1 to 511. `done_o` rises on the clock after the sample at index 511 is stored.
- R7: While `done_o` is high, pattern matches and `force_i` change neither the flags nor the stored samples.
- R8: With `rd_en_i` high and `done_o` high, the sample at `rd_addr_i` appears on `rd_data_o` on the next clock with `rd_valid_o` high. With `done_o` low, `rd_valid_o` stays low.
- R9: `disarm_i` takes priority over `arm_i`. It returns the core to idle on the next clock and clears the latched first-stage match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Design clock; sampled on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| probe_i | input | 32 | Probe bus, used both for triggering and as captured data |
| arm_i | input | 1 | Arm pulse |
| disarm_i | input | 1 | Return to idle |
| force_i | input | 1 | Force an immediate trigger while armed |
| seq_en_i | input | 1 | Enable the two-stage sequence trigger |
| cfg_we_i | input | 1 | Pattern register write enable |
| cfg_sel_i | input | 2 | Pattern register select |
| cfg_data_i | input | 32 | Pattern register write data |
| rd_en_i | input | 1 | Readback request |
| rd_addr_i | input | 9 | Readback index |
| rd_data_o | output | 32 | Readback sample |
| rd_valid_o | output | 1 | Readback data valid |
| armed_o | output | 1 | Waiting for a trigger |
| capturing_o | output | 1 | Filling the buffer after a trigger |
| done_o | output | 1 | Capture complete |

## Verification
The assertions assume that `arm_i`, `disarm_i` and `force_i` are treated as plain level inputs sampled on each edge, with the priority disarm, then arm, then the state machine. They also assume that `seq_en_i` and the pattern registers are held steady while the core is armed. The bench keeps to this. It drives every input half a cycle away from the active edge and gives commands as single-cycle pulses. It writes the patterns and sets `seq_en_i` only while the core is idle or done. The probe bus is driven as a counter or as chosen values, so that every stored sample can be predicted from the trigger value.

// File: rtl/la_capture.sv
module la_capture #(
  parameter int W = 32,
  parameter int DEPTH = 512,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  probe_i,
  input  logic          arm_i,
  input  logic          disarm_i,
  input  logic          force_i,
  input  logic          seq_en_i,
  input  logic          cfg_we_i,
  input  logic [1:0]    cfg_sel_i,
  input  logic [W-1:0]  cfg_data_i,
  input  logic          rd_en_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o,
  output logic          rd_valid_o,
  output logic          armed_o,
  output logic          capturing_o,
  output logic          done_o
);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_CAP, S_DONE} state_t;

  state_t        state;
  logic [AW-1:0] wr_ptr;
  logic          stage1;
  logic [W-1:0]  val_a, msk_a, val_b, msk_b;
  logic [W-1:0]  mem [DEPTH];

  wire hit_a = ((probe_i ^ val_a) & msk_a) == '0;
  wire hit_b = ((probe_i ^ val_b) & msk_b) == '0;
  wire cmd   = arm_i | disarm_i;
  wire fire  = (state == S_ARMED) && !cmd &&
               (force_i || (seq_en_i ? (stage1 && hit_b) : hit_a));
  wire last  = wr_ptr == AW'(DEPTH - 1);
  wire wr_en = fire || ((state == S_CAP) && !cmd);
  wire [AW-1:0] wr_addr = fire ? '0 : wr_ptr;

  assign armed_o     = state == S_ARMED;
  assign capturing_o = state == S_CAP;
  assign done_o      = state == S_DONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      val_a <= '0; msk_a <= '0; val_b <= '0; msk_b <= '0;
    end else if (cfg_we_i) begin
      case (cfg_sel_i)
        2'd0: val_a <= cfg_data_i;
        2'd1: msk_a <= cfg_data_i;
        2'd2: val_b <= cfg_data_i;
        default: msk_b <= cfg_data_i;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      wr_ptr <= '0;
      stage1 <= 1'b0;
    end else if (disarm_i) begin
      state  <= S_IDLE;
      stage1 <= 1'b0;
    end else if (arm_i) begin
      state  <= S_ARMED;
      stage1 <= 1'b0;
      wr_ptr <= '0;
    end else begin
      case (state)
        S_ARMED: begin
          if (fire) begin
            state  <= S_CAP;
            wr_ptr <= AW'(1);
          end else if (seq_en_i && hit_a) begin
            stage1 <= 1'b1;
          end
        end
        S_CAP: begin
          wr_ptr <= wr_ptr + AW'(1);
          if (last) state <= S_DONE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= probe_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i && done_o;
      if (rd_en_i && done_o) rd_data_o <= mem[rd_addr_i];
    end
  end

  a_r1_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({armed_o, capturing_o, done_o}));

  a_r2_arm_takes: assert property (@(posedge clk) disable iff (!rst_n)
    arm_i && !disarm_i |=> armed_o && !done_o);

  a_r5_force_fires: assert property (@(posedge clk) disable iff (!rst_n)
    armed_o && force_i && !cmd |=> capturing_o);

  a_r6_capture_ends_done: assert property (@(posedge clk) disable iff (!rst_n)
    capturing_o && !cmd |=> capturing_o || done_o);

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !cmd |=> done_o);

  a_r8_no_read_before_done: assert property (@(posedge clk) disable iff (!rst_n)
    !done_o |=> !rd_valid_o);

  a_r9_disarm_idles: assert property (@(posedge clk) disable iff (!rst_n)
    disarm_i |=> !armed_o && !capturing_o && !done_o);

endmodule

// File: tb/la_capture_tb.sv
module la_capture_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] probe_i = '0;
  logic        arm_i = 0, disarm_i = 0, force_i = 0, seq_en_i = 0;
  logic        cfg_we_i = 0;
  logic [1:0]  cfg_sel_i = '0;
  logic [31:0] cfg_data_i = '0;
  logic        rd_en_i = 0;
  logic [8:0]  rd_addr_i = '0;
  logic [31:0] rd_data_o;
  logic        rd_valid_o, armed_o, capturing_o, done_o;
  int errors = 0, checks = 0;

  always #10 clk = ~clk;

  la_capture u_dut (
    .clk(clk), .rst_n(rst_n), .probe_i(probe_i), .arm_i(arm_i),
    .disarm_i(disarm_i), .force_i(force_i), .seq_en_i(seq_en_i),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_data_i(cfg_data_i),
    .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .rd_valid_o(rd_valid_o), .armed_o(armed_o), .capturing_o(capturing_o),
    .done_o(done_o));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk); cfg_we_i = 1; cfg_sel_i = sel; cfg_data_i = d;
    @(negedge clk); cfg_we_i = 0;
  endtask

  task automatic pulse_arm(input logic [31:0] p);
    @(negedge clk); arm_i = 1; probe_i = p;
    @(negedge clk); arm_i = 0;
  endtask

  task automatic run_count(input int n);
    for (int i = 0; i < n; i++) begin
      probe_i = probe_i + 1;
      @(negedge clk);
    end
  endtask

  task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
    @(negedge clk); rd_en_i = 1; rd_addr_i = 9'(a);
    @(negedge clk); rd_en_i = 0;
    check({req, " valid"}, {31'b0, rd_valid_o}, 32'd1);
    check({req, " data"}, rd_data_o, exp);
  endtask

  task automatic t_reset;
    check("R1 armed", {31'b0, armed_o}, 0);
    check("R1 capturing", {31'b0, capturing_o}, 0);
    check("R1 done", {31'b0, done_o}, 0);
    check("R1 rd_valid", {31'b0, rd_valid_o}, 0);
  endtask

  task automatic t_ternary;
    seq_en_i = 0;
    wr_cfg(2'd0, 32'h0000_0000);
    wr_cfg(2'd1, 32'h0000_00FF);
    pulse_arm(32'h1234_56F0);
    check("R2 armed after arm", {31'b0, armed_o}, 1);
    @(negedge clk); rd_en_i = 1; rd_addr_i = '0;
    @(negedge clk); rd_en_i = 0;
    check("R8 no valid while armed", {31'b0, rd_valid_o}, 0);
    run_count(700);
    check("R6 done after window", {31'b0, done_o}, 1);
    rd_chk("R3 trigger sample", 0, 32'h1234_5700);
    rd_chk("R6 index 1", 1, 32'h1234_5701);
    rd_chk("R6 index 511", 511, 32'h1234_58FF);
  endtask

  task automatic t_force;
    seq_en_i = 0;
    wr_cfg(2'd0, 32'hDEAD_BEEF);
    wr_cfg(2'd1, 32'hFFFF_FFFF);
    pulse_arm(32'h0000_0100);
    check("R2 arm clears done", {31'b0, done_o}, 0);
    run_count(4);
    check("R3 no false trigger", {31'b0, armed_o}, 1);
    probe_i = 32'h0000_0200; force_i = 1;
    @(negedge clk); force_i = 0;
    check("R5 force trigger", {31'b0, capturing_o}, 1);
    run_count(510);
    check("R6 not done before 512", {31'b0, done_o}, 0);
    run_count(1);
    check("R6 done at 512", {31'b0, done_o}, 1);
    rd_chk("R5 index 0", 0, 32'h0000_0200);
    rd_chk("R5 index 5", 5, 32'h0000_0205);
  endtask

  task automatic t_done_ignore;
    wr_cfg(2'd1, 32'h0);
    probe_i = 32'h0000_FFFF; force_i = 1;
    @(negedge clk); force_i = 0;
    run_count(3);
    check("R7 done kept", {31'b0, done_o}, 1);
    check("R7 no recapture", {31'b0, capturing_o}, 0);
    rd_chk("R7 buffer intact", 0, 32'h0000_0200);
  endtask

  task automatic t_sequence;
    wr_cfg(2'd0, 32'h0000_00AA);
    wr_cfg(2'd1, 32'h0000_00FF);
    wr_cfg(2'd2, 32'h0000_00BB);
    wr_cfg(2'd3, 32'h0000_00FF);
    seq_en_i = 1;
    pulse_arm(32'h0);
    probe_i = 32'h0000_00BB; @(negedge clk);
    check("R4 second stage alone", {31'b0, armed_o}, 1);
    probe_i = 32'h0000_00AA; @(negedge clk);
    check("R4 first stage alone", {31'b0, armed_o}, 1);
    probe_i = 32'h0000_0011; @(negedge clk);
    probe_i = 32'h0000_00BB; @(negedge clk);
    check("R4 sequence fires", {31'b0, capturing_o}, 1);
    run_count(520);
    check("R4 done", {31'b0, done_o}, 1);
    rd_chk("R4 index 0", 0, 32'h0000_00BB);
    rd_chk("R4 index 1", 1, 32'h0000_00BC);
  endtask

  task automatic t_disarm;
    seq_en_i = 1;
    pulse_arm(32'h0);
    probe_i = 32'h0000_00AA; @(negedge clk);
    disarm_i = 1; arm_i = 1; probe_i = 32'h0;
    @(negedge clk); disarm_i = 0; arm_i = 0;
    check("R9 disarm wins", {31'b0, armed_o}, 0);
    pulse_arm(32'h0);
    probe_i = 32'h0000_00BB; @(negedge clk);
    run_count(2);
    check("R9 stage cleared", {31'b0, armed_o}, 1);
    check("R9 no trigger", {31'b0, capturing_o}, 0);
    disarm_i = 1; @(negedge clk); disarm_i = 0;
    check("R9 idle", {29'b0, armed_o, capturing_o, done_o}, 0);
    seq_en_i = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_ternary();
    t_force();
    t_done_ignore();
    t_sequence();
    t_disarm();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule